// File: doc/BRIEF.md
# DMA Completion Interrupt Generator

This block keeps the word count of one DMA channel and decides when the channel's completion interrupt fires. Software loads the count. The DMA sequencer then reports each internal word transfer with a strobe. For transmit channels, it also reports each issued external write and each external write acknowledge. The block produces a one-cycle interrupt pulse for the interrupt controller and a level that is high while the channel is busy.

A mode input selects where the interrupt is placed. In internal-completion mode, the pulse follows the last internal word in either direction, even if external writes are still in flight. In access-completion mode, a transmit channel holds the pulse until every issued external write has been acknowledged. A receive channel still fires on its last internal word. The count can only raise the interrupt by reaching zero through real transfers. A software write of zero stops the channel silently. A software write of one lets exactly one more word move and then fires the interrupt.

The controller has three states:
- IDLE: the channel is stopped.
- RUN: words are moving.
- DRAIN: the count has reached zero and the block waits for external acknowledges.

It has these transitions:
- START: IDLE to RUN, on a nonzero write.
- ABORT: RUN or DRAIN to IDLE, on a zero write.
- RELOAD: RUN or DRAIN to RUN, on a nonzero write.
- FINISH: RUN to IDLE, on the last word when no drain is needed.
- SETTLE: RUN to DRAIN, on the last word in access-completion transmit.
- FLUSHED: DRAIN to IDLE, once no writes are outstanding.

FINISH and FLUSHED raise the interrupt.

Top module: `dma_done_irq`

## Requirements
- R1: After reset, `irq` is 0, `busy` is 0 and `count` is 0.
- R2: While idle, a count write with a nonzero value loads `count` and sets `busy` at the next clock edge. A count write of zero leaves the channel idle.
- R3: In RUN, each cycle with `word_stb`=1 and no count write lowers `count` by one. `word_stb` while idle has no effect on `count`.
- R4: With `access_mode`=0, the word strobe that takes `count` from 1 to 0 raises `irq` at the next clock edge. In that same edge `busy` clears. This holds for both values of `tx_dir` and with external writes still outstanding.
- R5: A count write of zero while busy clears `busy` at the next edge and never raises `irq`.
- R6: A count write of one while busy lets exactly one further word strobe be counted, and then `irq` is raised as in R4.
- R7: When a count write and a word strobe occur in the same cycle, the written value is loaded and the strobe is not counted.
- R8: With `access_mode`=1 and `tx_dir`=1, the last word moves the channel to DRAIN. `busy` stays 1 and `irq` stays 0 while the outstanding-write count is nonzero. The outstanding count rises on `xw_issue` and falls on `xw_ack`. `irq` rises one edge after the edge at which the outstanding count becomes zero.
- R9: With `access_mode`=1 and `tx_dir`=0, `irq` fires with the same timing as in R4.
- R10: `irq` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_we | input | 1 | Software count write strobe |
| cnt_wdata | input | CNT_W | Value written to the count |
| access_mode | input | 1 | 0 = interrupt on internal completion, 1 = on access completion |
| tx_dir | input | 1 | 1 = external write (transmit), 0 = external read (receive) |
| word_stb | input | 1 | One internal word transferred |
| xw_issue | input | 1 | One external write issued |
| xw_ack | input | 1 | One external write acknowledged |
| count | output | CNT_W | Current remaining word count |
| busy | output | 1 | Channel active |
| irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
The hardest situation to reach is DRAIN with writes still outstanding. The stimulus must leave the external acknowledges behind the internal word strobes, so that the count reaches zero before the last acknowledge. The bench issues external writes together with the word strobes and holds every acknowledge back until after the final word. It then releases the acknowledges one at a time and checks that the pulse stays low until the final acknowledge. A second scenario leaves writes outstanding in internal-completion mode. It confirms that the pulse does not wait for them, and then drains them before the next test.

// File: rtl/dma_done_pkg.sv
package dma_done_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } chan_state_t;
endpackage

// File: rtl/dma_word_counter.sv
module dma_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - ONE;
    end

    // R7: a software load always wins over a counted word
    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R3: each counted word lowers the count by exactly one
    p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt != '0) |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/dma_pend_counter.sv
module dma_pend_counter #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [PEND_W-1:0] pend,
    output logic              pend_zero
);
    localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] P1   = PEND_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (inc && !dec && pend != PMAX)
            pend <= pend + P1;
        else if (dec && !inc && pend != '0)
            pend <= pend - P1;
    end

    assign pend_zero = (pend == '0);

    // R8: the outstanding-write tally follows issues and acknowledges
    p_pend_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && pend != PMAX) |=> pend == $past(pend) + P1);
    p_pend_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && pend != '0) |=> pend == $past(pend) - P1);
endmodule

// File: rtl/dma_done_irq.sv
module dma_done_irq
    import dma_done_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PEND_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             access_mode,
    input  logic             tx_dir,
    input  logic             word_stb,
    input  logic             xw_issue,
    input  logic             xw_ack,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    chan_state_t       state, state_nx;
    logic              fire;
    logic              count_word;
    logic              last_word;
    logic              need_drain;
    logic              pend_zero;
    logic [PEND_W-1:0] pend;
    logic              wr_zero;

    assign wr_zero    = (cnt_wdata == '0);
    assign count_word = (state == ST_RUN) && word_stb && !cnt_we;
    assign last_word  = count_word && (count == CNT_ONE);
    assign need_drain = access_mode && tx_dir;

    dma_word_counter #(.CNT_W(CNT_W)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_we),
        .load_val (cnt_wdata),
        .dec      (count_word),
        .cnt      (count)
    );

    dma_pend_counter #(.PEND_W(PEND_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (xw_issue),
        .dec       (xw_ack),
        .pend      (pend),
        .pend_zero (pend_zero)
    );

    // next-state and completion decision
    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cnt_we && !wr_zero)
                    state_nx = ST_RUN;                 // START
            end
            ST_RUN: begin
                if (cnt_we)
                    state_nx = wr_zero ? ST_IDLE : ST_RUN;   // ABORT / RELOAD
                else if (last_word) begin
                    if (need_drain)
                        state_nx = ST_DRAIN;           // SETTLE
                    else begin
                        state_nx = ST_IDLE;            // FINISH
                        fire     = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (cnt_we)
                    state_nx = wr_zero ? ST_IDLE : ST_RUN;   // ABORT / RELOAD
                else if (pend_zero) begin
                    state_nx = ST_IDLE;                // FLUSHED
                    fire     = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq  <= 1'b0;
            busy <= 1'b0;
        end else begin
            irq  <= fire;
            busy <= (state_nx != ST_IDLE);
        end
    end

    // R10: interrupt is a single-cycle pulse
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R4: busy is already low when the pulse appears
    p_busy_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);
    // R5: a zero write never produces an interrupt
    p_zero_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && wr_zero) |=> !irq);
    // R8: no interrupt while external writes are outstanding in drain
    p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !pend_zero) |=> !irq);
    // R2: the channel only becomes busy through a nonzero write
    p_start_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(cnt_we && !wr_zero)) |=> !busy);
endmodule

// File: tb/dma_done_irq_test.sv
`timescale 1ns/1ps
module dma_done_irq_test;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_we = 1'b0;
    logic [CW-1:0] cnt_wdata = '0;
    logic          access_mode = 1'b0;
    logic          tx_dir = 1'b0;
    logic          word_stb = 1'b0;
    logic          xw_issue = 1'b0;
    logic          xw_ack = 1'b0;
    logic [CW-1:0] count;
    logic          busy;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_done_irq #(.CNT_W(CW), .PEND_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .access_mode(access_mode), .tx_dir(tx_dir), .word_stb(word_stb),
        .xw_issue(xw_issue), .xw_ack(xw_ack),
        .count(count), .busy(busy), .irq(irq)
    );

    task automatic check(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // one cycle of stimulus: drive at negedge, outputs sampled at next negedge
    task automatic step(bit we, int wd, bit ws, bit iss, bit ack);
        cnt_we    = we;
        cnt_wdata = CW'(wd);
        word_stb  = ws;
        xw_issue  = iss;
        xw_ack    = ack;
        @(negedge clk);
        cnt_we = 0; word_stb = 0; xw_issue = 0; xw_ack = 0;
    endtask

    task automatic idle_cycle();
        step(0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        check("R1", "irq", irq, 0);
        check("R1", "busy", busy, 0);
        check("R1", "count", count, 0);
    endtask

    task automatic t_start_and_idle_strobe();
        step(0, 0, 1, 0, 0);
        check("R3", "idle strobe count", count, 0);
        check("R3", "idle strobe busy", busy, 0);
        step(1, 0, 0, 0, 0);
        check("R2", "zero write idle busy", busy, 0);
        check("R2", "zero write idle irq", irq, 0);
        step(1, 5, 0, 0, 0);
        check("R2", "start busy", busy, 1);
        check("R2", "start count", count, 5);
        step(0, 0, 1, 0, 0);
        check("R3", "dec count", count, 4);
        step(1, 9, 1, 0, 0);
        check("R7", "write wins count", count, 9);
        check("R7", "write wins busy", busy, 1);
        step(1, 0, 0, 0, 0);
        check("R5", "abort busy", busy, 0);
        check("R5", "abort irq", irq, 0);
        idle_cycle();
        check("R5", "abort irq later", irq, 0);
    endtask

    task automatic t_internal(bit dir);
        access_mode = 0; tx_dir = dir;
        step(1, 3, 0, 0, 0);
        step(0, 0, 1, dir, 0);
        step(0, 0, 1, dir, 0);
        check("R4", "not yet irq", irq, 0);
        step(0, 0, 1, dir, 0);
        check("R4", "irq on last word", irq, 1);
        check("R4", "busy clears with irq", busy, 0);
        check("R4", "count zero", count, 0);
        idle_cycle();
        check("R10", "irq one cycle", irq, 0);
        if (dir) begin
            for (int i = 0; i < 3; i++) idle_cycle();
            for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
        end
    endtask

    task automatic t_write_one();
        access_mode = 0; tx_dir = 0;
        step(1, 20, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(1, 1, 0, 0, 0);
        check("R6", "count after write one", count, 1);
        check("R6", "busy after write one", busy, 1);
        idle_cycle();
        check("R6", "no irq before word", irq, 0);
        step(0, 0, 1, 0, 0);
        check("R6", "irq after one word", irq, 1);
        check("R6", "busy after one word", busy, 0);
        idle_cycle();
    endtask

    task automatic t_access_tx();
        access_mode = 1; tx_dir = 1;
        step(1, 2, 0, 0, 0);
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 1, 0);
        check("R8", "count zero", count, 0);
        check("R8", "drain busy", busy, 1);
        check("R8", "drain no irq", irq, 0);
        idle_cycle();
        check("R8", "hold with 2 pending", irq, 0);
        step(0, 0, 0, 0, 1);
        check("R8", "hold with 1 pending", irq, 0);
        step(0, 0, 0, 0, 1);
        check("R8", "hold at ack edge", irq, 0);
        check("R8", "busy at ack edge", busy, 1);
        idle_cycle();
        check("R8", "irq after drain", irq, 1);
        check("R8", "busy cleared", busy, 0);
        idle_cycle();
        check("R10", "single pulse", irq, 0);
    endtask

    task automatic t_access_rx();
        access_mode = 1; tx_dir = 0;
        step(1, 2, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        check("R9", "rx irq on last word", irq, 1);
        check("R9", "rx busy", busy, 0);
        idle_cycle();
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                if (!finished) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog expired");
                    $display("CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_and_idle_strobe();
        t_internal(1'b0);
        t_internal(1'b1);
        t_write_one();
        t_access_tx();
        t_access_rx();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule